// File: doc/BRIEF.md
# Multiphase Regulator Startup Sequencer

This block is the top-level control state machine of a multiphase buck regulator. It watches two supply-lockout flags, an enable level and a gate-driver-ready signal. After enable it runs a timed startup delay, a calibration window and a phase-configuration window, then raises the driver-enable output. It waits for the driver to release its hold-off, checks the boot code, refreshes the bootstrap capacitors and soft-starts a digital reference code toward its target. It then stays in regulation until a fault arrives or enable or a supply is removed.

The reference is an 8-bit code of 5 mV per LSB. A prescaler moves it by one LSB per period: SLOW_DIV clocks for soft start and slow retargeting, and FAST_DIV clocks for fast retargeting and for the over-voltage discharge. At 200 MHz the defaults give 5 mV/µs and 20 mV/µs. Each phase gets a two-bit PWM mode for the modulator. A boot code of zero parks the sequencer until the first serial target is loaded. Over-current and over-voltage faults arrive already decoded and latch until enable or a supply is cycled.

Top module: `vr_startup_seq`

## Requirements
- R1: While `vcc_ok_i` or `vin_ok_i` is low, from the next clock edge on, `drv_en_o`=0, `pgood_o`=0, `ref_code_o`=0 and every phase mode is low (2'b00).
- R2: With both supplies good and `en_i` low, from the next edge on, `drv_en_o`=0, `pgood_o`=0, `ref_code_o`=0 and every phase mode is mid (2'b01).
- R3: `drv_en_o` rises START_CYC+CAL_CYC+CFG_CYC cycles after the edge that first samples `en_i` high in the disabled state.
- R4: While `drv_rdy_i` is low after `drv_en_o` has risen, startup holds: `ref_code_o` stays 0 and all phases stay mid.
- R5: If `boot_code_i` is 0 when the hold-off ends, the sequencer parks with all phases mid and `ref_code_o`=0 until `vid_load_i` loads `vid_code_i`. That code then becomes the soft-start target.
- R6: A nonzero boot code, or a load while parked, starts a bootstrap refresh: all phases low (2'b00) for exactly REFRESH_CYC cycles, followed by soft start toward the boot code or the loaded code.
- R7: Soft start begins with all phases mid. It moves `ref_code_o` up from 0 one LSB every SLOW_DIV cycles, with the first step SLOW_DIV cycles after soft start begins.
- R8: During soft start and regulation, a phase moves from mid (2'b01) to switching (2'b10) on the cycle after its first `pulse_i` bit and stays switching. Phases without a pulse stay mid.
- R9: In regulation, `vid_load_i` retargets the reference. It steps by one LSB toward the new code every FAST_DIV cycles when `fast_slew_i`=1 and every SLOW_DIV cycles otherwise, and `pgood_o` stays high.
- R10: `pgood_o` rises PG_DLY+1 cycles after the edge at which `ref_code_o` first equals the soft-start target, and is never high outside regulation or a fault latch.
- R11: An over-current flag in soft start or regulation drives `drv_en_o` low and all phases low at the next edge and freezes `ref_code_o`. `pgood_o` falls PG_DLY cycles after that edge. The state latches after `ocp_i` clears.
- R12: An over-voltage flag in soft start or regulation keeps `drv_en_o` high and forces all phases low. It ramps `ref_code_o` to 0 one LSB every FAST_DIV cycles and drops `pgood_o` PG_DLY cycles after the edge that samples the flag. The state latches.
- R13: Only low enable or a lost supply clears a fault latch; the full startup sequence then runs again.
- R14: Fault flags are ignored before soft start and do not change the startup timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Regulator enable level |
| vcc_ok_i | input | 1 | Control supply above lockout |
| vin_ok_i | input | 1 | Input/ramp supply above lockout |
| drv_rdy_i | input | 1 | Gate driver has released the enable line |
| boot_code_i | input | CODE_W | Programmed boot reference code |
| vid_load_i | input | 1 | Strobe: load a new serial target |
| vid_code_i | input | CODE_W | Serial target code |
| fast_slew_i | input | 1 | Use fast rate for retargeting |
| ocp_i | input | 1 | Decoded over-current fault |
| ovp_i | input | 1 | Decoded over-voltage fault |
| pulse_i | input | NPH | Per-phase first-pulse indication from modulator |
| ref_code_o | output | CODE_W | Digital reference code |
| pgood_o | output | 1 | Power-good |
| drv_en_o | output | 1 | Gate driver enable |
| pwm_mode_o | output | 2*NPH | Per-phase mode, 2 bits each, phase k at bits [2k+1:2k] |

## Verification
The bench counts cycles exactly on every timed edge. It checks the enable-to-driver delay with fault pulses injected during the delay: a design that acts on early faults would never raise driver-enable. It checks the bootstrap refresh length, the interval between every reference step in both directions and at both rates, and the power-good rise and fall delays. An off-by-one in any prescaler or dwell counter shows up as a wrong interval. It checks both boot paths: a parking design that skipped the wait would ramp with no target. It releases fault flags to prove the latch holds, then clears the latch through a supply drop and confirms the sequence restarts.

// File: rtl/vrseq_pkg.sv
`timescale 1ns/1ps
package vrseq_pkg;

    typedef enum logic [3:0] {
        ST_POR, ST_DIS, ST_DELAY, ST_CAL, ST_CFG, ST_ARM,
        ST_PARK, ST_REFRESH, ST_SOFT, ST_NORMAL, ST_OCP, ST_OVP
    } seq_state_e;

    // Mode encoding exported to the modulator.
    typedef enum logic [1:0] {
        PWM_LOW = 2'b00,
        PWM_MID = 2'b01,
        PWM_SW  = 2'b10
    } pwm_mode_e;

    typedef enum logic [1:0] {
        SEL_LOW, SEL_MID, SEL_LIVE
    } ph_sel_e;

    typedef struct packed {
        logic run;
        logic fast;
    } slew_ctl_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // States in which the reference is held at zero.
    function automatic logic clears_ref(input seq_state_e s);
        return s inside {ST_POR, ST_DIS, ST_DELAY, ST_CAL, ST_CFG,
                         ST_ARM, ST_PARK, ST_REFRESH};
    endfunction

    function automatic logic drives_gate(input seq_state_e s);
        return s inside {ST_ARM, ST_PARK, ST_REFRESH, ST_SOFT,
                         ST_NORMAL, ST_OVP};
    endfunction

    function automatic ph_sel_e phase_sel(input seq_state_e s);
        if (s inside {ST_SOFT, ST_NORMAL})
            return SEL_LIVE;
        if (s inside {ST_POR, ST_REFRESH, ST_OCP, ST_OVP})
            return SEL_LOW;
        return SEL_MID;
    endfunction

endpackage

// File: rtl/vrseq_dwell.sv
`timescale 1ns/1ps
module vrseq_dwell #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    output logic [W-1:0] count_o
);
    // Cycles spent in the current state; saturates.
    always_ff @(posedge clk) begin
        if (rst || restart)
            count_o <= '0;
        else if (count_o != {W{1'b1}})
            count_o <= count_o + 1'b1;
    end
endmodule

// File: rtl/vrseq_slew.sv
`timescale 1ns/1ps
module vrseq_slew
    import vrseq_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int SLOW_DIV = 200,
    parameter int FAST_DIV = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  slew_ctl_t         ctl,
    input  logic [CODE_W-1:0] target,
    output logic [CODE_W-1:0] code_o
);
    localparam int PW = $clog2(imax(SLOW_DIV, FAST_DIV) + 1);
    localparam logic [PW-1:0] SLOW_LAST = PW'(SLOW_DIV - 1);
    localparam logic [PW-1:0] FAST_LAST = PW'(FAST_DIV - 1);

    logic [PW-1:0] pre_q;
    logic [PW-1:0] lim;

    assign lim = ctl.fast ? FAST_LAST : SLOW_LAST;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            code_o <= '0;
            pre_q  <= '0;
        end else if (ctl.run && code_o != target) begin
            if (pre_q == lim) begin
                pre_q  <= '0;
                code_o <= (target > code_o) ? code_o + 1'b1 : code_o - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end else begin
            pre_q <= '0;
        end
    end

    // R7 / R9: the reference never jumps by more than one LSB
    assert_one_lsb_step_R7: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (code_o == $past(code_o) || code_o == $past(code_o) + 1'b1 ||
                  code_o == $past(code_o) - 1'b1));

    // R9: a step only happens while the ramp is running
    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (!clr && !ctl.run) |=> $stable(code_o));
endmodule

// File: rtl/vrseq_phase.sv
`timescale 1ns/1ps
module vrseq_phase
    import vrseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ph_sel_e   sel,
    input  logic      pulse_i,
    output pwm_mode_e mode_o
);
    logic sw_q;

    always_ff @(posedge clk) begin
        if (rst || sel != SEL_LIVE)
            sw_q <= 1'b0;
        else if (pulse_i)
            sw_q <= 1'b1;
    end

    always_comb begin
        unique case (sel)
            SEL_LIVE: mode_o = sw_q ? PWM_SW : PWM_MID;
            SEL_MID:  mode_o = PWM_MID;
            default:  mode_o = PWM_LOW;
        endcase
    end

    // R8: a phase only starts switching after its own pulse
    assert_sw_after_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_o == PWM_SW && $past(mode_o) != PWM_SW) |-> $past(pulse_i));
endmodule

// File: rtl/vr_startup_seq.sv
`timescale 1ns/1ps
module vr_startup_seq
    import vrseq_pkg::*;
#(
    parameter int NPH         = 4,
    parameter int CODE_W      = 8,
    parameter int START_CYC   = 1000000,
    parameter int CAL_CYC     = 2000,
    parameter int CFG_CYC     = 6000,
    parameter int REFRESH_CYC = 200,
    parameter int SLOW_DIV    = 200,
    parameter int FAST_DIV    = 50,
    parameter int PG_DLY      = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              vcc_ok_i,
    input  logic              vin_ok_i,
    input  logic              drv_rdy_i,
    input  logic [CODE_W-1:0] boot_code_i,
    input  logic              vid_load_i,
    input  logic [CODE_W-1:0] vid_code_i,
    input  logic              fast_slew_i,
    input  logic              ocp_i,
    input  logic              ovp_i,
    input  logic [NPH-1:0]    pulse_i,
    output logic [CODE_W-1:0] ref_code_o,
    output logic              pgood_o,
    output logic              drv_en_o,
    output logic [2*NPH-1:0]  pwm_mode_o
);
    localparam int MAXC = imax(imax(imax(START_CYC, CAL_CYC), imax(CFG_CYC, REFRESH_CYC)), PG_DLY);
    localparam int DW   = $clog2(MAXC + 1);
    localparam logic [DW-1:0] START_LAST = DW'(START_CYC - 1);
    localparam logic [DW-1:0] CAL_LAST   = DW'(CAL_CYC - 1);
    localparam logic [DW-1:0] CFG_LAST   = DW'(CFG_CYC - 1);
    localparam logic [DW-1:0] REF_LAST   = DW'(REFRESH_CYC - 1);
    localparam logic [DW-1:0] PG_LAST    = DW'(PG_DLY - 1);
    localparam logic [2*NPH-1:0] ALL_MID = {NPH{2'b01}};

    seq_state_e        state_q, state_d;
    logic [DW-1:0]     dwell_q;
    logic [CODE_W-1:0] tgt_q;
    logic [CODE_W-1:0] slew_tgt;
    slew_ctl_t         sctl;
    logic              pg_q, pg_d;
    logic              fault_ov, fault_oc;

    assign fault_ov = ovp_i;
    assign fault_oc = ocp_i;

    // Sequencer next state: lockout beats enable, enable beats everything else.
    always_comb begin
        state_d = state_q;
        if (!vcc_ok_i || !vin_ok_i)
            state_d = ST_POR;
        else if (state_q == ST_POR || !en_i)
            state_d = ST_DIS;
        else begin
            case (state_q)
                ST_DIS:     state_d = ST_DELAY;
                ST_DELAY:   if (dwell_q == START_LAST) state_d = ST_CAL;
                ST_CAL:     if (dwell_q == CAL_LAST)   state_d = ST_CFG;
                ST_CFG:     if (dwell_q == CFG_LAST)   state_d = ST_ARM;
                ST_ARM:     if (drv_rdy_i)
                                state_d = (boot_code_i == '0) ? ST_PARK : ST_REFRESH;
                ST_PARK:    if (vid_load_i) state_d = ST_REFRESH;
                ST_REFRESH: if (dwell_q == REF_LAST) state_d = ST_SOFT;
                ST_SOFT, ST_NORMAL: begin
                    if (fault_ov)
                        state_d = ST_OVP;
                    else if (fault_oc)
                        state_d = ST_OCP;
                    else if (state_q == ST_SOFT && ref_code_o == tgt_q)
                        state_d = ST_NORMAL;
                end
                default: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_POR;
        else
            state_q <= state_d;
    end

    vrseq_dwell #(.W(DW)) u_dwell (
        .clk     (clk),
        .rst     (rst),
        .restart (state_d != state_q),
        .count_o (dwell_q)
    );

    // Target: boot code until startup ends, serial loads afterwards.
    always_ff @(posedge clk) begin
        if (rst)
            tgt_q <= '0;
        else if (state_q inside {ST_POR, ST_DIS, ST_DELAY, ST_CAL, ST_CFG, ST_ARM})
            tgt_q <= boot_code_i;
        else if (vid_load_i && state_q inside {ST_PARK, ST_REFRESH, ST_SOFT, ST_NORMAL})
            tgt_q <= vid_code_i;
    end

    always_comb begin
        sctl.run  = state_q inside {ST_SOFT, ST_NORMAL, ST_OVP};
        sctl.fast = (state_q == ST_OVP) || (state_q == ST_NORMAL && fast_slew_i);
        slew_tgt  = (state_q == ST_OVP) ? '0 : tgt_q;
    end

    vrseq_slew #(
        .CODE_W   (CODE_W),
        .SLOW_DIV (SLOW_DIV),
        .FAST_DIV (FAST_DIV)
    ) u_slew (
        .clk    (clk),
        .rst    (rst),
        .clr    (clears_ref(state_d)),
        .ctl    (sctl),
        .target (slew_tgt),
        .code_o (ref_code_o)
    );

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        pwm_mode_e ph_mode;
        vrseq_phase u_phase (
            .clk     (clk),
            .rst     (rst),
            .sel     (phase_sel(state_q)),
            .pulse_i (pulse_i[g]),
            .mode_o  (ph_mode)
        );
        assign pwm_mode_o[2*g +: 2] = ph_mode;
    end

    // Power-good follows the next state so disable and lockout drop it at once.
    always_comb begin
        pg_d = 1'b0;
        if (state_d == ST_NORMAL)
            pg_d = pg_q | (state_q == ST_NORMAL && dwell_q == PG_LAST);
        else if (state_d == ST_OCP || state_d == ST_OVP)
            pg_d = pg_q & !(state_q == state_d && dwell_q == PG_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst)
            pg_q <= 1'b0;
        else
            pg_q <= pg_d;
    end

    assign pgood_o  = pg_q;
    assign drv_en_o = drives_gate(state_q);

    assert_lockout_safe_R1: assert property (@(posedge clk) disable iff (rst)
        (!vcc_ok_i || !vin_ok_i) |=>
            (!drv_en_o && !pgood_o && ref_code_o == '0 && pwm_mode_o == '0));

    assert_disable_safe_R2: assert property (@(posedge clk) disable iff (rst)
        (vcc_ok_i && vin_ok_i && !en_i) |=>
            (!drv_en_o && !pgood_o && ref_code_o == '0 && pwm_mode_o == ALL_MID));

    assert_pgood_scope_R10: assert property (@(posedge clk) disable iff (rst)
        pgood_o |-> state_q inside {ST_NORMAL, ST_OCP, ST_OVP});

    assert_ocp_latch_R11: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OCP && en_i && vcc_ok_i && vin_ok_i) |=>
            (state_q == ST_OCP && !drv_en_o && pwm_mode_o == '0 && $stable(ref_code_o)));

    assert_ovp_lowside_R12: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OVP) |-> (drv_en_o && pwm_mode_o == '0));
endmodule

// File: tb/vr_startup_seq_bench.sv
`timescale 1ns/1ps
module vr_startup_seq_bench;
    localparam int NPH = 4, CW = 8;
    localparam int S_C = 20, C_C = 5, F_C = 4, R_C = 6;
    localparam int SLOW = 6, FAST = 2, PG = 5;
    localparam logic [2*NPH-1:0] MID = 8'h55;

    logic clk = 1'b0;
    logic rst, en, vcc_ok, vin_ok, drv_rdy, vid_load, fast, ocp, ovp;
    logic [CW-1:0] boot, vid;
    logic [NPH-1:0] pulse;
    logic [CW-1:0] ref_code;
    logic pgood, drv_en;
    logic [2*NPH-1:0] pwm;

    int checks = 0, fails = 0, pg_fall_k = -1;
    bit done = 0;

    always #2.5 clk = ~clk;

    vr_startup_seq #(
        .NPH(NPH), .CODE_W(CW), .START_CYC(S_C), .CAL_CYC(C_C), .CFG_CYC(F_C),
        .REFRESH_CYC(R_C), .SLOW_DIV(SLOW), .FAST_DIV(FAST), .PG_DLY(PG)
    ) u_vr_startup_seq (
        .clk(clk), .rst(rst), .en_i(en), .vcc_ok_i(vcc_ok), .vin_ok_i(vin_ok),
        .drv_rdy_i(drv_rdy), .boot_code_i(boot), .vid_load_i(vid_load),
        .vid_code_i(vid), .fast_slew_i(fast), .ocp_i(ocp), .ovp_i(ovp),
        .pulse_i(pulse), .ref_code_o(ref_code), .pgood_o(pgood),
        .drv_en_o(drv_en), .pwm_mode_o(pwm)
    );

    function automatic int exp_drv_delay(input int extra);
        return S_C + C_C + F_C + 1 + extra;
    endfunction

    function automatic int exp_div(input logic f);
        return f ? FAST : SLOW;
    endfunction

    task automatic chk(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_drv(output int n, input bit inject);
        n = 0;
        while (!drv_en && n < 2000) begin
            step();
            n++;
            if (inject && n == 4) begin ocp = 1; ovp = 1; end
            if (inject && n == 6) begin ocp = 0; ovp = 0; end
        end
    endtask

    task automatic count_refresh(output int c);
        c = 0;
        while (pwm == '0 && c < 1000) begin
            c++;
            step();
        end
    endtask

    task automatic ramp(input logic [CW-1:0] tgt, input int div, output int bad);
        int last = 0, k = 0;
        logic [CW-1:0] prev = ref_code;
        logic pg_prev = pgood;
        bad = 0;
        pg_fall_k = -1;
        while (ref_code != tgt && k < 5000) begin
            step();
            k++;
            if (pg_prev && !pgood && pg_fall_k < 0) pg_fall_k = k;
            pg_prev = pgood;
            if (ref_code != prev) begin
                if (k - last != div) bad++;
                if (!((tgt > prev && ref_code == prev + 1'b1) ||
                      (tgt < prev && ref_code == prev - 1'b1))) bad++;
                last = k;
                prev = ref_code;
            end
        end
        if (ref_code != tgt) bad++;
    endtask

    task automatic wait_pgood(output int n);
        n = 0;
        while (!pgood && n < 1000) begin step(); n++; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n, bad, c;
        logic [CW-1:0] t, cur;
        void'($urandom(32'd7731));
        rst = 1; en = 0; vcc_ok = 0; vin_ok = 0; drv_rdy = 0; vid_load = 0;
        fast = 0; ocp = 0; ovp = 0; pulse = '0; vid = '0;
        boot = CW'(10 + $urandom_range(0, 25));
        repeat (3) step();
        rst = 0;
        step(); step();
        // R1: lockout state
        chk("R1 drv_en in lockout", drv_en, 0);
        chk("R1 pwm low in lockout", pwm, 0);
        chk("R1 ref zero in lockout", ref_code, 0);
        vcc_ok = 1; vin_ok = 1;
        step(); step();
        chk("R2 pwm mid when disabled", pwm, MID);
        chk("R2 drv_en when disabled", drv_en, 0);

        // R3 / R14: enable, with faults pulsed during the delay
        en = 1;
        wait_drv(n, 1'b1);
        chk("R3 R14 enable to driver-enable cycles", n, exp_drv_delay(0));
        // R4: driver hold-off
        for (int i = 0; i < 12; i++) begin
            step();
            if (ref_code != 0 || pwm != MID) bad = 1;
        end
        chk("R4 hold-off ref", ref_code, 0);
        chk("R4 hold-off pwm mid", pwm, MID);
        drv_rdy = 1;
        step();
        count_refresh(c);
        chk("R6 refresh length", c, R_C);
        chk("R7 soft start begins mid", pwm, MID);
        ramp(boot, SLOW, bad);
        chk("R7 soft start step timing", bad, 0);
        wait_pgood(n);
        chk("R10 pgood rise delay", n, PG + 1);

        // R8: per-phase first pulse
        pulse = 4'b0001;
        step();
        pulse = '0;
        step();
        chk("R8 phase0 switching", pwm[1:0], 2);
        chk("R8 phase1 still mid", pwm[3:2], 1);
        pulse = 4'b0100;
        step();
        pulse = '0;
        step();
        chk("R8 phase0 sticky, phase2 switching", pwm, 8'h56 + 8'h10);

        // R9: random retargeting
        cur = ref_code;
        for (int i = 0; i < 5; i++) begin
            t = CW'($urandom_range(0, 50));
            if (t == cur) t = cur + 1'b1;
            fast = 1'($urandom_range(0, 1));
            vid = t;
            vid_load = 1;
            step();
            vid_load = 0;
            ramp(t, exp_div(fast), bad);
            chk("R9 retarget step timing", bad, 0);
            chk("R9 pgood held while retargeting", pgood, 1);
            cur = t;
        end

        // R11: over-current latch
        ocp = 1;
        step();
        chk("R11 drv_en drops", drv_en, 0);
        chk("R11 phases low", pwm, 0);
        chk("R11 ref frozen", ref_code, cur);
        n = 1;
        while (pgood && n < 1000) begin step(); n++; end
        chk("R11 pgood fall delay", n, PG + 1);
        ocp = 0;
        repeat (8) step();
        chk("R11 latched after flag clears", drv_en, 0);
        chk("R11 ref still frozen", ref_code, cur);

        // R13 / R2: enable low clears the latch
        en = 0;
        step();
        chk("R2 R13 pwm mid after disable", pwm, MID);
        chk("R2 R13 ref cleared", ref_code, 0);
        chk("R2 pgood low", pgood, 0);

        // R5: zero boot code parks
        boot = '0;
        en = 1;
        wait_drv(n, 1'b0);
        chk("R3 second enable delay", n, exp_drv_delay(0));
        for (int i = 0; i < 20; i++) step();
        chk("R5 parked pwm mid", pwm, MID);
        chk("R5 parked ref zero", ref_code, 0);
        t = CW'(20 + $urandom_range(0, 20));
        vid = t;
        vid_load = 1;
        step();
        vid_load = 0;
        count_refresh(c);
        chk("R5 R6 refresh after first load", c + 0, R_C);
        ramp(t, SLOW, bad);
        chk("R5 soft start to loaded code", bad, 0);
        wait_pgood(n);
        chk("R10 pgood rise second run", n, PG + 1);

        // R12: over-voltage latch
        ovp = 1;
        step();
        ovp = 0;
        chk("R12 drv_en stays high", drv_en, 1);
        chk("R12 phases low", pwm, 0);
        ramp('0, FAST, bad);
        chk("R12 discharge step timing", bad, 0);
        chk("R12 pgood fall delay", pg_fall_k, PG);
        repeat (6) step();
        chk("R12 latched drv_en", drv_en, 1);
        chk("R12 latched phases low", pwm, 0);

        // R13 / R1: supply loss clears, sequence restarts
        vin_ok = 0;
        step();
        chk("R1 R13 lockout drv_en", drv_en, 0);
        chk("R1 R13 lockout pwm", pwm, 0);
        vin_ok = 1;
        wait_drv(n, 1'b0);
        chk("R13 restart after supply", n, exp_drv_delay(1));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule